// File: doc/BRIEF.md
# Interleaved Multi-Bank Burst Memory

The block is a word memory split into several equal banks. Each bank holds its own address register, data register, access countdown and storage. A burst read is requested with a start address and a word count. The controller starts one bank access per cycle, walking through the burst addresses in order. A bank access takes a fixed number of cycles, so accesses to different banks overlap in time. Each finished word is returned on a single shared read bus, one word per cycle, in address order.

A mode input chooses how an address is split into bank number and row. In the spread (low-order) split, consecutive addresses fall in different banks, so a burst of n words needs T+(n-1) cycles from the first access. In the block (high-order) split, consecutive addresses fall in the same bank, and every access waits for the previous one to finish, which gives nT cycles. Single-word writes load the banks directly while no burst is running.

Top module: `ilv_mem`

## Requirements
- R1: After reset, `rd_valid` and `done` are low.
- R2: A write (`wr_en` high at a clock edge while no burst runs) stores `wr_data` at `wr_addr`, and a later burst over that address returns it.
- R3: With `map_high` = 0, bank = address bits [1:0] and row = address bits [5:2].
- R4: With `map_high` = 1, bank = address bits [5:4] and row = address bits [3:0].
- R5: In the low-order split, with the start sampled at edge E, word k of the burst is on the bus after edge E+1+T+k, where T = 4.
- R6: In the high-order split, word k is on the bus after edge E+1+(k+1)T, because each access waits for the previous access to the same bank.
- R7: Words leave in address order, one per `rd_valid` cycle, and addresses wrap modulo 64.
- R8: `done` is high for exactly one cycle, directly after the cycle that carries the last word.
- R9: A `start` during a running burst is ignored, and a `start` with length 0 is ignored.
- R10: A write while a burst runs is ignored and leaves the stored word unchanged.
- R11: The split mode is captured at start, so changing `map_high` mid-burst changes neither the timing nor the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_high | input | 1 | 0: low-order split, 1: high-order split |
| wr_en | input | 1 | Single-word write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| start | input | 1 | Burst request strobe |
| start_addr | input | 6 | First burst address |
| start_len | input | 7 | Words in the burst (0 = no request) |
| rd_valid | output | 1 | Read word present on the bus |
| rd_data | output | 16 | Read word |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
Counting from the edge that samples `start`, the first access issues one edge later, and its word appears T edges after that. In the low-order split, the following words appear on consecutive edges. In the high-order split, they appear every T edges, and `done` follows the last word by one edge. The bench drives inputs and samples outputs on falling edges, and it numbers every edge after the start edge. On each of those cycles it compares `rd_valid` and `done` against the edge numbers computed from these formulas. Whenever a word is due, it also checks the data against its own model of the bank storage.

// File: rtl/ilv_pkg.sv
// Shared types for the interleaved bank memory.
package ilv_pkg;
    // How an address is split into bank number and row.
    typedef enum logic {
        MAP_LOW  = 1'b0,
        MAP_HIGH = 1'b1
    } map_e;
endpackage

// File: rtl/ilv_map.sv
// Address splitter: turns a flat word address into a bank number and a row.
// Assumes BW >= 1 and AW > BW. The split is purely combinational.
module ilv_map
    import ilv_pkg::*;
#(
    parameter int AW = 6,
    parameter int BW = 2
) (
    input  logic [AW-1:0]    addr,
    input  map_e             mode,
    output logic [BW-1:0]    bank,
    output logic [AW-BW-1:0] row
);
    // Pick the bank field from the top or bottom of the address.
    always_comb begin
        if (mode == MAP_HIGH) begin
            bank = addr[AW-1 -: BW];
            row  = addr[AW-BW-1:0];
        end else begin
            bank = addr[BW-1:0];
            row  = addr[AW-1:BW];
        end
    end
endmodule

// File: rtl/ilv_bank.sv
// One memory bank with its own address register, data register and access timer.
// An issued access returns its word in the data register exactly ACC_T edges
// later, with a one-cycle vld pulse. The bank accepts a new access on the same
// edge that completes the old one. Assumes ACC_T >= 2.
module ilv_bank #(
    parameter int DW    = 16,
    parameter int RW    = 4,
    parameter int ACC_T = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [RW-1:0] issue_row,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_row,
    input  logic [DW-1:0] wr_data,
    output logic          free,
    output logic          vld,
    output logic [DW-1:0] dreg
);
    localparam int CW    = $clog2(ACC_T);
    localparam int DEPTH = 1 << RW;

    logic [DW-1:0] store [DEPTH];
    logic [RW-1:0] areg;
    logic [CW-1:0] rem;
    logic          busy;

    // The bank is free when idle or when it finishes on this edge.
    assign free = !busy || (rem == '0);

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_row] <= wr_data;
    end

    // Access timer, address register and data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            rem  <= '0;
            areg <= '0;
            vld  <= 1'b0;
            dreg <= '0;
        end else begin
            vld <= 1'b0;
            if (busy && rem == '0) begin
                dreg <= store[areg];
                vld  <= 1'b1;
                busy <= 1'b0;
            end else if (busy) begin
                rem <= rem - 1'b1;
            end
            if (issue) begin
                busy <= 1'b1;
                areg <= issue_row;
                rem  <= CW'(ACC_T - 1);
            end
        end
    end
endmodule

// File: rtl/ilv_seq.sv
// Burst sequencer: captures a request and walks its addresses in order.
// It issues at most one bank access per cycle, and holds back when the target
// bank is still busy. Assumes fin arrives only while a burst is active.
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 6,
    parameter int BW = 2,
    parameter int LW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic [LW-1:0]    start_len,
    input  map_e             mode_in,
    input  logic             fin,
    input  logic [NB-1:0]    bank_free,
    output logic             active,
    output logic [NB-1:0]    issue,
    output logic [AW-BW-1:0] issue_row,
    output logic [LW-1:0]    burst_len
);
    logic [AW-1:0] cur;
    logic [LW-1:0] left;
    map_e          mode_q;
    logic [BW-1:0] bsel;
    logic          go;

    ilv_map #(.AW(AW), .BW(BW)) u_map (
        .addr(cur), .mode(mode_q), .bank(bsel), .row(issue_row)
    );

    // Issue when words remain and the target bank can accept.
    always_comb begin
        go          = active && (left != '0) && bank_free[bsel];
        issue       = '0;
        issue[bsel] = go;
    end

    // Request capture, address walk and burst end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cur       <= '0;
            left      <= '0;
            burst_len <= '0;
            mode_q    <= MAP_LOW;
        end else if (!active) begin
            if (start && start_len != '0) begin
                active    <= 1'b1;
                cur       <= start_addr;
                left      <= start_len;
                burst_len <= start_len;
                mode_q    <= mode_in;
            end
        end else begin
            if (go) begin
                cur  <= cur + 1'b1;
                left <= left - 1'b1;
            end
            if (fin) active <= 1'b0;
        end
    end
endmodule

// File: rtl/ilv_ret.sv
// Shared return bus: forwards the single finishing bank's word and counts
// returned words against the burst length. Assumes at most one bank completes
// per cycle, which holds because issues are at most one per cycle with fixed latency.
module ilv_ret #(
    parameter int NB = 4,
    parameter int DW = 16,
    parameter int LW = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NB-1:0]          bank_vld,
    input  logic [NB-1:0][DW-1:0]  bank_data,
    input  logic [LW-1:0]          burst_len,
    output logic                   rd_valid,
    output logic [DW-1:0]          rd_data,
    output logic                   fin,
    output logic                   done
);
    logic [LW-1:0] cnt;

    // Bus mux: OR together the data of the completing bank.
    always_comb begin
        rd_valid = |bank_vld;
        rd_data  = '0;
        for (int b = 0; b < NB; b++) begin
            if (bank_vld[b]) rd_data = rd_data | bank_data[b];
        end
        fin = rd_valid && (cnt == burst_len - 1'b1);
    end

    // Returned-word counter and end-of-burst pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= fin;
            if (fin)           cnt <= '0;
            else if (rd_valid) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ilv_mem.sv
// Interleaved multi-bank memory with burst reads over a shared bus.
// Writes go straight to one bank and are accepted only while no burst runs.
// Assumes NBANK and BANK_WORDS are powers of two, NBANK >= 2 and ACC_T >= 2.
module ilv_mem
    import ilv_pkg::*;
#(
    parameter int NBANK      = 4,
    parameter int BANK_WORDS = 16,
    parameter int DATA_W     = 16,
    parameter int ACC_T      = 4,
    localparam int BW        = $clog2(NBANK),
    localparam int RW        = $clog2(BANK_WORDS),
    localparam int AW        = BW + RW,
    localparam int LW        = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_high,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [LW-1:0]     start_len,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    logic                         burst_act;
    logic [NBANK-1:0]             bank_free;
    logic [NBANK-1:0]             bank_vld;
    logic [NBANK-1:0]             bank_issue;
    logic [NBANK-1:0][DATA_W-1:0] bank_data;
    logic [RW-1:0]                issue_row;
    logic [LW-1:0]                burst_len;
    logic                         fin;
    logic [BW-1:0]                wbank;
    logic [RW-1:0]                wrow;
    logic                         wr_go;

    ilv_map #(.AW(AW), .BW(BW)) u_wmap (
        .addr(wr_addr), .mode(map_e'(map_high)), .bank(wbank), .row(wrow)
    );

    // Writes are blocked while a burst is in progress.
    assign wr_go = wr_en && !burst_act;

    ilv_seq #(.NB(NBANK), .AW(AW), .BW(BW), .LW(LW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_len(start_len), .mode_in(map_e'(map_high)), .fin(fin),
        .bank_free(bank_free), .active(burst_act), .issue(bank_issue),
        .issue_row(issue_row), .burst_len(burst_len)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ilv_bank #(.DW(DATA_W), .RW(RW), .ACC_T(ACC_T)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .issue(bank_issue[b]), .issue_row(issue_row),
            .wr_en(wr_go && (wbank == BW'(b))), .wr_row(wrow), .wr_data(wr_data),
            .free(bank_free[b]), .vld(bank_vld[b]), .dreg(bank_data[b])
        );
    end

    ilv_ret #(.NB(NBANK), .DW(DATA_W), .LW(LW)) u_ret (
        .clk(clk), .rst_n(rst_n), .bank_vld(bank_vld), .bank_data(bank_data),
        .burst_len(burst_len), .rd_valid(rd_valid), .rd_data(rd_data),
        .fin(fin), .done(done)
    );
endmodule

// File: rtl/ilv_mem_chk.sv
// Protocol checker for ilv_mem, attached with bind. It only observes.
module ilv_mem_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid,
    input logic          done,
    input logic          active,
    input logic [NB-1:0] bank_vld,
    input logic [NB-1:0] bank_issue
);
    // R7: the shared bus carries at most one bank's word per cycle.
    p_one_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_vld));

    // R8: done only follows a cycle that carried a word.
    p_done_after_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_valid));

    // R8: done is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the burst has ended when done is raised.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active);

    // R9: no bank access and no bus word outside a burst.
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!rd_valid && bank_issue == '0));
endmodule

bind ilv_mem ilv_mem_chk #(.NB(NBANK)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .done(done),
    .active(burst_act), .bank_vld(bank_vld), .bank_issue(bank_issue)
);

// File: tb/sim_ilv_mem.sv
// Directed bench for ilv_mem: one task per scenario, each checking its own results.
module sim_ilv_mem;
    localparam int T = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        map_high;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [15:0] wr_data;
    logic        start;
    logic [5:0]  start_addr;
    logic [6:0]  start_len;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [15:0] model [64];

    always #10 clk = ~clk;

    ilv_mem u0 (
        .clk(clk), .rst_n(rst_n), .map_high(map_high), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
        .start_addr(start_addr), .start_len(start_len),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
    );

    // Bench-side address split: bank*16 + row (R3 low-order, R4 high-order).
    function automatic int phys(input int a, input bit hi);
        int m;
        m = a % 64;
        if (hi) return ((m >> 4) & 3) * 16 + (m & 15);
        return (m & 3) * 16 + (m >> 2);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_word(input int a, input logic [15:0] d, input bit hi);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d; map_high = hi;
        @(negedge clk);
        wr_en = 1'b0;
        model[phys(a, hi)] = d;
    endtask

    // Burst with cycle-exact checks. act: 0 none, 1 extra start, 2 write, 3 flip mode.
    task automatic run_burst(input string req, input int a, input int n, input bit hi,
                             input int act, input int act_at, input int act_arg);
        int last;
        int lim;
        @(negedge clk);
        start = 1'b1; start_addr = 6'(a); start_len = 7'(n); map_high = hi;
        @(negedge clk);
        start = 1'b0;
        last = hi ? 1 + n * T : T + n;
        lim  = last + 8;
        for (int i = 1; i <= lim; i++) begin
            bit expv;
            int j;
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
            if (hi) begin
                expv = (i >= 1 + T) && (i <= 1 + n * T) && ((i - 1) % T == 0);
                j    = (i - 1) / T - 1;
            end else begin
                expv = (i >= 1 + T) && (i < 1 + T + n);
                j    = i - 1 - T;
            end
            check(req, 32'(rd_valid), 32'(expv), $sformatf("rd_valid at edge %0d", i));
            if (expv && rd_valid)
                check(req, 32'(rd_data), 32'(model[phys(a + j, hi)]),
                      $sformatf("word %0d data", j));
            check(req, 32'(done), 32'(i == last + 1), $sformatf("done at edge %0d", i));
            if (i == act_at) begin
                if (act == 1) begin
                    start = 1'b1; start_addr = 6'(act_arg); start_len = 7'd3;
                end else if (act == 2) begin
                    wr_en = 1'b1; wr_addr = 6'(act_arg); wr_data = 16'hDEAD;
                end else if (act == 3) begin
                    map_high = !hi;
                end
            end
        end
        map_high = hi;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; map_high = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        start = 1'b0; start_addr = '0; start_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(rd_valid), 32'd0, "rd_valid after reset");
        check("R1", 32'(done), 32'd0, "done after reset");
    endtask

    task automatic t_fill();
        for (int a = 0; a < 64; a++) write_word(a, 16'(16'h1000 + a * 16'h0111), 1'b0);
    endtask

    task automatic t_zero_len();
        @(negedge clk);
        start = 1'b1; start_addr = 6'd5; start_len = 7'd0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R9", 32'(rd_valid | done), 32'd0, "zero-length start output");
        end
    endtask

    initial begin
        t_reset();
        t_fill();
        run_burst("R3 R5 R7 R8", 0, 8, 1'b0, 0, 0, 0);
        run_burst("R4 R6 R8", 3, 5, 1'b1, 0, 0, 0);
        run_burst("R7 wrap", 62, 4, 1'b0, 0, 0, 0);
        run_burst("R5 single", 17, 1, 1'b0, 0, 0, 0);
        write_word(10, 16'hBEEF, 1'b0);
        run_burst("R2", 9, 3, 1'b0, 0, 0, 0);
        write_word(33, 16'h7777, 1'b1);
        run_burst("R2 R4", 32, 3, 1'b1, 0, 0, 0);
        run_burst("R9 busy start", 8, 6, 1'b0, 1, 2, 40);
        t_zero_len();
        run_burst("R10", 20, 6, 1'b0, 2, 3, 50);
        run_burst("R10 readback", 50, 1, 1'b0, 0, 0, 0);
        run_burst("R11", 0, 6, 1'b1, 3, 3, 0);
        run_burst("R5 full", 40, 20, 1'b0, 0, 0, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule